// File: doc/BRIEF.md
# Codec Reset and Power-Down Sequencer

This block supervises the start-up and low-power states of a codec's digital core. Everything runs on the master clock. An asynchronous reset pin and an active-low hardware power-down pin are each brought into the clock domain by a two-stage synchronizer. The synchronizer raises its output at once and releases it only after two clock edges. Once reset is released, a fixed initialization window keeps the serial port in high impedance. The block then enters normal operation.

Two software power-down bits from a control register switch off the DAC path and the ADC path separately. A new bit value is taken only at a frame-sync pulse, so a converter never stops or starts in the middle of a frame. While the power-down pin is low, hardware power-down overrides everything. The core clock and the digital interface are switched off, and the port goes to high impedance. When the pin returns high, the initialization window runs again. The software power-down state held inside the block survives both power-down modes. The analog output is held at its midpoint whenever the DAC path is not driving.

Top module: `pwrseq_top`

## Requirements
- R1: While `rst_pin_n` is low, the outputs are `port_hiz`=1, `adc_en`=0, `dac_en`=0, `aout_mid`=1, `dif_en`=1 and `core_clk_en`=1. `port_hiz` rises without waiting for a clock edge. Reset clears both held software power-down bits, so both converters are enabled after start-up until a frame-sync captures new bits.
- R2: After `rst_pin_n` rises, `port_hiz` falls after exactly 134 rising clock edges (2 synchronizer edges plus 132 initialization cycles). During that window `adc_en`=0, `dac_en`=0 and `aout_mid`=1.
- R3: A change on `swpd_dac` or `swpd_adc` has no effect on the outputs until a rising edge at which `fsync`=1. The new value shows on the outputs right after that edge.
- R4: Outside hardware power-down and after initialization, `swpd_dac`=1 gives `dac_en`=0 and `aout_mid`=1, and `swpd_adc`=1 gives `adc_en`=0. The two bits act independently. In every software power-down combination, `dif_en`=1 and `port_hiz`=0.
- R5: Once `pdn_pin_n` is low, after the next rising edge `core_clk_en`=0, `dif_en`=0, `port_hiz`=1, `adc_en`=0, `dac_en`=0 and `aout_mid`=1.
- R6: After `pdn_pin_n` returns high, `port_hiz` falls after exactly 135 rising edges (2 synchronizer edges, 1 exit edge and 132 initialization cycles).
- R7: During hardware power-down, `fsync` pulses and changes on the software bits are ignored. After exit, the converters follow the software bits that were held before entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| pdn_pin_n | input | 1 | Asynchronous hardware power-down pin, active low |
| fsync | input | 1 | Frame-sync pulse, one clock wide |
| swpd_dac | input | 1 | Software power-down request for the DAC path |
| swpd_adc | input | 1 | Software power-down request for the ADC path |
| port_hiz | output | 1 | Serial port high-impedance request |
| adc_en | output | 1 | ADC path enable |
| dac_en | output | 1 | DAC path enable |
| aout_mid | output | 1 | Hold analog output at midpoint |
| dif_en | output | 1 | Digital interface enable |
| core_clk_en | output | 1 | Core clock enable |

## Verification
The software power-down path is driven through a sequence of bit pairs that covers each single-converter shutdown, full shutdown and recovery from full shutdown. A hold period without frame-sync comes before each capture, so a design that reacts to a bit immediately fails the check. A design that swaps the DAC and ADC roles also fails, because the pairs are asymmetric. The initialization length is measured edge by edge after reset release and again after hardware power-down exit. The two expected counts differ by one, which separates the direct reset entry from the exit edge out of hardware power-down. A frame-sync given during hardware power-down with changed bits shows whether the held state is protected. A reset during full software power-down shows whether the held bits are cleared.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;
    typedef enum logic [1:0] {
        PS_INIT = 2'd0,
        PS_RUN  = 2'd1,
        PS_HWPD = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic dac;
        logic adc;
    } swpd_bits_t;
endpackage

// File: rtl/pwrseq_sync.sv
`timescale 1ns/1ps
// Active-low synchronizer: assertion (low) passes through at once,
// release is delayed by STAGES clock edges.
module pwrseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge async_n) begin
        if (!async_n) sh_q <= '0;
        else          sh_q <= sh_d;
    end

    assign sync_n = sh_q[STAGES-1];

    // R5 / R1: a low input is never seen as released at a clock edge
    assert_assert_wins_R5: assert property (@(posedge clk) !async_n |-> !sync_n);
endmodule

// File: rtl/pwrseq_fsm.sv
`timescale 1ns/1ps
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int INIT_CYCLES = 132
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n,
    output pwr_state_e state_o
);
    localparam int CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

    typedef struct packed {
        pwr_state_e       state;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.state)
            PS_INIT: begin
                if (!pdn_n) begin
                    fsm_d.state = PS_HWPD;
                    fsm_d.cnt   = '0;
                end else if (fsm_q.cnt == CNT_LAST) begin
                    fsm_d.state = PS_RUN;
                    fsm_d.cnt   = '0;
                end else begin
                    fsm_d.cnt = fsm_q.cnt + 1'b1;
                end
            end
            PS_RUN: begin
                if (!pdn_n) fsm_d.state = PS_HWPD;
            end
            PS_HWPD: begin
                if (pdn_n) begin
                    fsm_d.state = PS_INIT;
                    fsm_d.cnt   = '0;
                end
            end
            default: begin
                fsm_d.state = PS_INIT;
                fsm_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: PS_INIT, cnt: '0};
        else        fsm_q <= fsm_d;
    end

    assign state_o = fsm_q.state;

    // R2 / R6: normal operation is entered only from the last initialization count
    assert_init_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == PS_RUN && $past(fsm_q.state) == PS_INIT) |-> $past(fsm_q.cnt) == CNT_LAST);
    // R5: a synchronized power-down request always ends in the power-down state
    assert_hwpd_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_n |=> fsm_q.state == PS_HWPD);
endmodule

// File: rtl/pwrseq_swpd.sv
`timescale 1ns/1ps
module pwrseq_swpd
    import pwrseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic sw_dac,
    input  logic sw_adc,
    output logic pd_dac,
    output logic pd_adc
);
    swpd_bits_t bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (capture) begin
            bits_d.dac = sw_dac;
            bits_d.adc = sw_adc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign pd_dac = bits_q.dac;
    assign pd_adc = bits_q.adc;

    // R3: held bits change only at a capture
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bits_q));
    // R3: a capture loads the requested bits
    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (bits_q.dac == $past(sw_dac) && bits_q.adc == $past(sw_adc)));
endmodule

// File: rtl/pwrseq_top.sv
`timescale 1ns/1ps
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int INIT_CYCLES = 132
) (
    input  logic clk,
    input  logic rst_pin_n,
    input  logic pdn_pin_n,
    input  logic fsync,
    input  logic swpd_dac,
    input  logic swpd_adc,
    output logic port_hiz,
    output logic adc_en,
    output logic dac_en,
    output logic aout_mid,
    output logic dif_en,
    output logic core_clk_en
);
    localparam int N_PINS = 2;

    logic [N_PINS-1:0] pin_n, pin_s_n;
    logic              rst_s_n, pdn_s_n;
    pwr_state_e        state;
    logic              pd_dac, pd_adc, capture;
    logic              in_run, in_hwpd;

    assign pin_n = {pdn_pin_n, rst_pin_n};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        pwrseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .async_n(pin_n[g]),
            .sync_n (pin_s_n[g])
        );
    end

    assign rst_s_n = pin_s_n[0];
    assign pdn_s_n = pin_s_n[1];

    pwrseq_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_s_n),
        .pdn_n  (pdn_s_n),
        .state_o(state)
    );

    assign in_run  = (state == PS_RUN);
    assign in_hwpd = (state == PS_HWPD);
    assign capture = fsync && pdn_s_n && !in_hwpd;

    pwrseq_swpd u_swpd (
        .clk    (clk),
        .rst_n  (rst_s_n),
        .capture(capture),
        .sw_dac (swpd_dac),
        .sw_adc (swpd_adc),
        .pd_dac (pd_dac),
        .pd_adc (pd_adc)
    );

    assign port_hiz    = !in_run;
    assign adc_en      = in_run && !pd_adc;
    assign dac_en      = in_run && !pd_dac;
    assign aout_mid    = !dac_en;
    assign dif_en      = !in_hwpd;
    assign core_clk_en = !in_hwpd;

    // R5: a synchronized power-down request stops the core clock one edge later
    assert_clk_gate_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
        !pdn_s_n |=> (!core_clk_en && !dif_en));
    // R4: converters can only be on while the port is driven
    assert_port_live_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
        (adc_en || dac_en) |-> !port_hiz);
endmodule

// File: tb/tb_pwrseq_top.sv
`timescale 1ns/1ps
module tb_pwrseq_top;
    localparam int SYNC_N = 2;
    localparam int INIT_N = 132;
    localparam int NVEC   = 6;
    // each entry: {swpd_dac, swpd_adc}
    localparam logic [1:0] VEC [NVEC] = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b11, 2'b10};

    logic clk = 0;
    logic rst_pin_n = 0, pdn_pin_n = 1, fsync = 0, swpd_dac = 0, swpd_adc = 0;
    logic port_hiz, adc_en, dac_en, aout_mid, dif_en, core_clk_en;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    pwrseq_top dut (
        .clk(clk), .rst_pin_n(rst_pin_n), .pdn_pin_n(pdn_pin_n), .fsync(fsync),
        .swpd_dac(swpd_dac), .swpd_adc(swpd_adc), .port_hiz(port_hiz),
        .adc_en(adc_en), .dac_en(dac_en), .aout_mid(aout_mid),
        .dif_en(dif_en), .core_clk_en(core_clk_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic conv(input string req, input logic dac_off, input logic adc_off);
        chk({req, " adc_en"}, int'(adc_en), int'(!adc_off));
        chk({req, " dac_en"}, int'(dac_en), int'(!dac_off));
        chk({req, " aout_mid"}, int'(aout_mid), int'(dac_off));
    endtask

    task automatic pulse_fsync();
        fsync = 1;
        step();
        fsync = 0;
    endtask

    // counts edges until port_hiz falls; also flags any converter enabled meanwhile
    task automatic time_init(output int n, output int leak);
        n = 0; leak = 0;
        do begin
            step();
            n++;
            if (port_hiz && (adc_en || dac_en || !aout_mid)) leak++;
        end while (port_hiz && n < 1000);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, leak;
        logic cur_dac, cur_adc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 port_hiz", int'(port_hiz), 1);
        conv("R1", 1, 1);
        chk("R1 dif_en", int'(dif_en), 1);
        chk("R1 core_clk_en", int'(core_clk_en), 1);

        // R2: initialization length after reset release
        rst_pin_n = 1;
        time_init(n, leak);
        chk("R2 init edges", n, SYNC_N + INIT_N);
        chk("R2 converters off during init", leak, 0);
        conv("R1 cleared bits", 0, 0);

        // R3 / R4: vector walk over software power-down pairs
        cur_dac = 0; cur_adc = 0;
        for (int i = 0; i < NVEC; i++) begin
            swpd_dac = VEC[i][1];
            swpd_adc = VEC[i][0];
            repeat (3) step();
            conv("R3 no fsync hold", cur_dac, cur_adc);
            pulse_fsync();
            cur_dac = VEC[i][1];
            cur_adc = VEC[i][0];
            conv("R4 after fsync", cur_dac, cur_adc);
            chk("R4 dif_en", int'(dif_en), 1);
            chk("R4 port_hiz", int'(port_hiz), 0);
        end

        // R5: hardware power-down entry (held bits: dac off, adc on)
        pdn_pin_n = 0;
        step();
        chk("R5 core_clk_en", int'(core_clk_en), 0);
        chk("R5 dif_en", int'(dif_en), 0);
        chk("R5 port_hiz", int'(port_hiz), 1);
        conv("R5", 1, 1);

        // R7: changes and fsync during power-down are ignored
        swpd_dac = 0; swpd_adc = 1;
        step();
        pulse_fsync();
        repeat (2) step();
        chk("R7 core_clk_en still off", int'(core_clk_en), 0);

        // R6: exit runs initialization again
        pdn_pin_n = 1;
        time_init(n, leak);
        chk("R6 exit edges", n, SYNC_N + 1 + INIT_N);
        chk("R6 converters off during init", leak, 0);
        conv("R7 held bits kept", 1, 0);
        chk("R6 core_clk_en", int'(core_clk_en), 1);
        pulse_fsync();
        conv("R7 capture after exit", 0, 1);

        // R1: reset during full software power-down
        swpd_dac = 1; swpd_adc = 1;
        pulse_fsync();
        conv("R4 full swpd", 1, 1);
        rst_pin_n = 0;
        #1;
        chk("R1 async port_hiz", int'(port_hiz), 1);
        step();
        rst_pin_n = 1;
        time_init(n, leak);
        chk("R2 init edges again", n, SYNC_N + INIT_N);
        conv("R1 bits cleared by reset", 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule